// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block sits between a set of external interrupt sources and a local interrupt controller. Every redirection pin owns a 64-bit entry that says how a request on that pin is interpreted (input polarity, edge or level trigger, mask) and what message it becomes (vector, delivery mode, destination, destination mode). Requests latch into a pending register. A scanner walks the pins in ascending order and turns each pending, unmasked request into one delivery message for the local controller.

Level-triggered pins latch a remote-pending flag when they are delivered. While that flag is set, the pin is not delivered again. An end-of-interrupt broadcast that carries the pin's vector clears the flag, and if the level request is still present the pin is delivered again. Edge requests that arrive while the pin is masked are thrown away. Source number 0 is steered onto pin 2. A pin whose delivery mode asks for an externally supplied vector fetches that vector from a legacy controller over a request/acknowledge pair before the message goes out.

Deliveries leave on a valid/ready stream. While `dlv_valid` is high and `dlv_ready` is low, the message does not change and the scan is frozen. Nothing else is issued until the message is accepted. Source events, entry writes and end-of-interrupt broadcasts are single-cycle strobes with no back-pressure. None of them is lost while the output is stalled.

Top module: `irq_route_engine`

## Requirements
- R1: After synchronous reset, every entry reads back as 0x0000_0000_0001_0000 (only the mask bit 16 set), nothing is pending, and neither `dlv_valid` nor `ext_req` is high.
- R2: Entry layout: vector [7:0], delivery mode [10:8], destination mode [11], polarity [13], remote-pending [14], trigger [15] (1 = level, 0 = edge), mask [16] (1 = masked), destination [63:56]. A write stores every field except remote-pending, which keeps its value. Bits 12 and 55:17 read as zero. A write also starts a service pass.
- R3: When polarity is 1, the source level is inverted before any other processing, so a low level is the active one.
- R4: In level mode, an active level sets the pin's pending bit even while the pin is masked. An inactive level clears it, and a request withdrawn this way is never delivered.
- R5: In edge mode, an active level on an unmasked pin sets pending. An active level on a masked pin is discarded: unmasking later delivers nothing. An inactive level has no effect.
- R6: Source index 0 drives pin 2, and every other index below the pin count drives the pin with the same number. Indices at or above the pin count are ignored.
- R7: When several pins are eligible, they are delivered in ascending pin order.
- R8: Each delivery carries the entry's vector, destination, destination mode and delivery mode, plus the trigger bit on `dlv_level`.
- R9: Delivering an edge pin clears its pending bit, so one edge gives one delivery. Delivering a level pin sets its remote-pending bit, and no further delivery of that pin happens while the bit is set.
- R10: An end-of-interrupt with vector V clears remote-pending on every entry whose vector is V. Such a pin is delivered again if it is still pending and unmasked. A non-matching vector changes nothing.
- R11: Delivery mode 3'b111 raises `ext_req` and holds it until `ext_ack`. The message then leaves with `ext_vector` in place of the entry's vector, and `dlv_valid` stays low while the fetch is open.
- R12: While `dlv_valid` is high and `dlv_ready` is low, the payload is held, `ext_req` stays low and no other delivery is issued. Requests that arrive meanwhile stay pending and are delivered afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Source event strobe |
| src_idx | input | SRC_W | Source number of the event |
| src_level | input | 1 | New level of that source |
| cfg_wr_en | input | 1 | Entry write strobe |
| cfg_wr_pin | input | PIN_W | Entry to write |
| cfg_wr_data | input | 64 | Entry write data |
| cfg_rd_pin | input | PIN_W | Entry to read |
| cfg_rd_data | output | 64 | Entry read data, combinational |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector of the broadcast |
| dlv_valid | output | 1 | Delivery message valid |
| dlv_ready | input | 1 | Local controller accepts the message |
| dlv_vector | output | 8 | Message vector |
| dlv_dest | output | 8 | Message destination |
| dlv_dest_mode | output | 1 | Message destination mode |
| dlv_mode | output | 3 | Message delivery mode |
| dlv_level | output | 1 | Message trigger bit (1 = level) |
| ext_req | output | 1 | Request for an externally supplied vector |
| ext_ack | input | 1 | External vector is present |
| ext_vector | input | 8 | Externally supplied vector |

## Verification
The bench builds the engine with 8 pins and a 4-bit source index. With that setting, all 16 source numbers can be swept, including 0 (steered to pin 2) and 8 to 15 (out of range and ignored). Every pin's message fields can be checked against formulas computed in the bench. The small pin count also lets a stalled delivery from the top pin force the scan to wrap and restart, which shows ascending order. The remote-pending and end-of-interrupt sequences run on a single level pin, and the external vector fetch runs on a single edge pin.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int ENTRY_W  = 64;
  localparam int B_VEC    = 0;
  localparam int B_MODE   = 8;
  localparam int B_DMODE  = 11;
  localparam int B_POL    = 13;
  localparam int B_REMOTE = 14;
  localparam int B_TRIG   = 15;
  localparam int B_MASK   = 16;
  localparam int B_DEST   = 56;

  localparam logic [2:0] DM_EXTERNAL = 3'b111;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig;
    logic       pol;
    logic       dmode;
    logic [2:0] mode;
    logic [7:0] vector;
  } pin_cfg_t;

  typedef struct packed {
    logic [7:0] vector;
    logic [7:0] dest;
    logic       dest_mode;
    logic [2:0] mode;
    logic       level;
  } dlv_msg_t;

  localparam pin_cfg_t RESET_CFG = '{dest: 8'h00, mask: 1'b1, trig: 1'b0, pol: 1'b0,
                                     dmode: 1'b0, mode: 3'd0, vector: 8'h00};

  function automatic logic [ENTRY_W-1:0] cfg_word(pin_cfg_t c, logic remote);
    logic [ENTRY_W-1:0] w;
    w = '0;
    w[B_DEST +: 8]  = c.dest;
    w[B_MASK]       = c.mask;
    w[B_TRIG]       = c.trig;
    w[B_REMOTE]     = remote;
    w[B_POL]        = c.pol;
    w[B_DMODE]      = c.dmode;
    w[B_MODE +: 3]  = c.mode;
    w[B_VEC +: 8]   = c.vector;
    return w;
  endfunction

endpackage

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [PIN_W-1:0]    wr_pin,
  input  logic [ENTRY_W-1:0]  wr_data,
  input  logic [PIN_W-1:0]    rd_pin,
  output logic [ENTRY_W-1:0]  rd_data,
  input  logic [PIN_W-1:0]    sel_pin,
  output dlv_msg_t            sel_msg,
  input  logic                take_valid,
  input  logic [PIN_W-1:0]    take_pin,
  input  logic                eoi_valid,
  input  logic [7:0]          eoi_vector,
  output logic                eoi_hit_any,
  output logic [NUM_PINS-1:0] pol_v,
  output logic [NUM_PINS-1:0] trig_v,
  output logic [NUM_PINS-1:0] mask_v,
  output logic [NUM_PINS-1:0] remote_v
);

  pin_cfg_t              cfg_a [NUM_PINS];
  pin_cfg_t              wr_cfg;
  logic [NUM_PINS-1:0]   eoi_hit;
  logic                  unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[55:17], wr_data[B_REMOTE], wr_data[12]};

  always_comb begin
    wr_cfg.dest   = wr_data[B_DEST +: 8];
    wr_cfg.mask   = wr_data[B_MASK];
    wr_cfg.trig   = wr_data[B_TRIG];
    wr_cfg.pol    = wr_data[B_POL];
    wr_cfg.dmode  = wr_data[B_DMODE];
    wr_cfg.mode   = wr_data[B_MODE +: 3];
    wr_cfg.vector = wr_data[B_VEC +: 8];
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pin_cfg_t cfg_q;
    logic     remote_q;
    logic     wr_sel;
    logic     take_sel;

    assign wr_sel   = wr_en && (wr_pin == PIN_W'(i));
    assign take_sel = take_valid && (take_pin == PIN_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q    <= RESET_CFG;
        remote_q <= 1'b0;
      end else begin
        if (wr_sel) cfg_q <= wr_cfg;
        if (eoi_hit[i])                 remote_q <= 1'b0;
        else if (take_sel && cfg_q.trig) remote_q <= 1'b1;
      end
    end

    assign eoi_hit[i]  = eoi_valid && remote_q && (cfg_q.vector == eoi_vector);
    assign cfg_a[i]    = cfg_q;
    assign pol_v[i]    = cfg_q.pol;
    assign trig_v[i]   = cfg_q.trig;
    assign mask_v[i]   = cfg_q.mask;
    assign remote_v[i] = remote_q;
  end

  assign eoi_hit_any = |eoi_hit;

  always_comb begin
    rd_data = '0;
    if (32'(rd_pin) < NUM_PINS) rd_data = cfg_word(cfg_a[rd_pin], remote_v[rd_pin]);
  end

  always_comb begin
    sel_msg = '0;
    if (32'(sel_pin) < NUM_PINS) begin
      sel_msg.vector    = cfg_a[sel_pin].vector;
      sel_msg.dest      = cfg_a[sel_pin].dest;
      sel_msg.dest_mode = cfg_a[sel_pin].dmode;
      sel_msg.mode      = cfg_a[sel_pin].mode;
      sel_msg.level     = cfg_a[sel_pin].trig;
    end
  end

endmodule

// File: rtl/irq_route_pending.sv
module irq_route_pending #(
  parameter int NUM_PINS  = 24,
  parameter int PIN_W     = 5,
  parameter int SRC_W     = 5,
  parameter int STEER_SRC = 0,
  parameter int STEER_PIN = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                src_valid,
  input  logic [SRC_W-1:0]    src_idx,
  input  logic                src_level,
  input  logic [NUM_PINS-1:0] pol_v,
  input  logic [NUM_PINS-1:0] trig_v,
  input  logic [NUM_PINS-1:0] mask_v,
  input  logic                take_valid,
  input  logic [PIN_W-1:0]    take_pin,
  output logic [NUM_PINS-1:0] pending_o,
  output logic                set_any
);

  logic [SRC_W-1:0]    tgt;
  logic [NUM_PINS-1:0] set_v;
  logic [NUM_PINS-1:0] clr_v;
  logic [NUM_PINS-1:0] pend_q;

  assign tgt = (src_idx == SRC_W'(STEER_SRC)) ? SRC_W'(STEER_PIN) : src_idx;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      logic hit;
      logic act;
      hit      = src_valid && (tgt == SRC_W'(i));
      act      = src_level ^ pol_v[i];
      set_v[i] = hit && act && (trig_v[i] || !mask_v[i]);
      clr_v[i] = (hit && !act && trig_v[i]) ||
                 (take_valid && (take_pin == PIN_W'(i)) && !trig_v[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_v) | set_v;
  end

  assign pending_o = pend_q;
  assign set_any   = |set_v;

endmodule

// File: rtl/irq_route_scan.sv
module irq_route_scan
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pass_req,
  input  logic [NUM_PINS-1:0] elig,
  output logic [PIN_W-1:0]    sel_pin,
  input  dlv_msg_t            sel_msg,
  output logic                take_valid,
  output logic [PIN_W-1:0]    take_pin,
  output logic                dlv_valid,
  input  logic                dlv_ready,
  output dlv_msg_t            dlv_msg,
  output logic                ext_req,
  input  logic                ext_ack,
  input  logic [7:0]          ext_vector
);

  localparam int PTR_W = PIN_W + 1;

  logic             active_q;
  logic             rerun_q;
  logic [PTR_W-1:0] ptr_q;
  logic             valid_q;
  logic             ext_q;
  dlv_msg_t         msg_q;
  logic             hit;
  logic [PIN_W-1:0] hit_idx;
  logic             busy;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (elig[i] && (PTR_W'(i) >= ptr_q)) begin
        hit     = 1'b1;
        hit_idx = PIN_W'(i);
      end
    end
  end

  assign busy       = valid_q || ext_q;
  assign take_valid = active_q && !busy && hit;
  assign take_pin   = hit_idx;
  assign sel_pin    = hit_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rerun_q  <= 1'b0;
      ptr_q    <= '0;
      valid_q  <= 1'b0;
      ext_q    <= 1'b0;
      msg_q    <= '0;
    end else begin
      if (valid_q && dlv_ready) valid_q <= 1'b0;
      if (ext_q && ext_ack) begin
        ext_q        <= 1'b0;
        valid_q      <= 1'b1;
        msg_q.vector <= ext_vector;
      end
      if (!active_q) begin
        if (pass_req) begin
          active_q <= 1'b1;
          ptr_q    <= '0;
          rerun_q  <= 1'b0;
        end
      end else if (busy) begin
        if (pass_req) rerun_q <= 1'b1;
      end else if (hit) begin
        msg_q <= sel_msg;
        ptr_q <= PTR_W'(hit_idx) + PTR_W'(1);
        if (pass_req) rerun_q <= 1'b1;
        if (sel_msg.mode == DM_EXTERNAL) ext_q <= 1'b1;
        else                             valid_q <= 1'b1;
      end else if (rerun_q || pass_req) begin
        ptr_q   <= '0;
        rerun_q <= 1'b0;
      end else begin
        active_q <= 1'b0;
      end
    end
  end

  assign dlv_valid = valid_q;
  assign dlv_msg   = msg_q;
  assign ext_req   = ext_q;

endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS  = 24,
  parameter int SRC_W     = 5,
  parameter int STEER_SRC = 0,
  parameter int STEER_PIN = 2,
  parameter int PIN_W     = $clog2(NUM_PINS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               src_valid,
  input  logic [SRC_W-1:0]   src_idx,
  input  logic               src_level,
  input  logic               cfg_wr_en,
  input  logic [PIN_W-1:0]   cfg_wr_pin,
  input  logic [63:0]        cfg_wr_data,
  input  logic [PIN_W-1:0]   cfg_rd_pin,
  output logic [63:0]        cfg_rd_data,
  input  logic               eoi_valid,
  input  logic [7:0]         eoi_vector,
  output logic               dlv_valid,
  input  logic               dlv_ready,
  output logic [7:0]         dlv_vector,
  output logic [7:0]         dlv_dest,
  output logic               dlv_dest_mode,
  output logic [2:0]         dlv_mode,
  output logic               dlv_level,
  output logic               ext_req,
  input  logic               ext_ack,
  input  logic [7:0]         ext_vector
);

  logic [NUM_PINS-1:0] pol_v, trig_v, mask_v, remote_v, pending, elig;
  logic                eoi_hit_any, set_any, pass_req;
  logic                take_valid;
  logic [PIN_W-1:0]    take_pin, sel_pin;
  dlv_msg_t            sel_msg, dlv_msg;

  irq_route_table #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_table (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (cfg_wr_en),
    .wr_pin      (cfg_wr_pin),
    .wr_data     (cfg_wr_data),
    .rd_pin      (cfg_rd_pin),
    .rd_data     (cfg_rd_data),
    .sel_pin     (sel_pin),
    .sel_msg     (sel_msg),
    .take_valid  (take_valid),
    .take_pin    (take_pin),
    .eoi_valid   (eoi_valid),
    .eoi_vector  (eoi_vector),
    .eoi_hit_any (eoi_hit_any),
    .pol_v       (pol_v),
    .trig_v      (trig_v),
    .mask_v      (mask_v),
    .remote_v    (remote_v)
  );

  irq_route_pending #(
    .NUM_PINS(NUM_PINS), .PIN_W(PIN_W), .SRC_W(SRC_W),
    .STEER_SRC(STEER_SRC), .STEER_PIN(STEER_PIN)
  ) u_pend (
    .clk        (clk),
    .rst        (rst),
    .src_valid  (src_valid),
    .src_idx    (src_idx),
    .src_level  (src_level),
    .pol_v      (pol_v),
    .trig_v     (trig_v),
    .mask_v     (mask_v),
    .take_valid (take_valid),
    .take_pin   (take_pin),
    .pending_o  (pending),
    .set_any    (set_any)
  );

  assign elig     = pending & ~mask_v & ~remote_v;
  assign pass_req = set_any || cfg_wr_en || eoi_hit_any;

  irq_route_scan #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_scan (
    .clk        (clk),
    .rst        (rst),
    .pass_req   (pass_req),
    .elig       (elig),
    .sel_pin    (sel_pin),
    .sel_msg    (sel_msg),
    .take_valid (take_valid),
    .take_pin   (take_pin),
    .dlv_valid  (dlv_valid),
    .dlv_ready  (dlv_ready),
    .dlv_msg    (dlv_msg),
    .ext_req    (ext_req),
    .ext_ack    (ext_ack),
    .ext_vector (ext_vector)
  );

  assign dlv_vector    = dlv_msg.vector;
  assign dlv_dest      = dlv_msg.dest;
  assign dlv_dest_mode = dlv_msg.dest_mode;
  assign dlv_mode      = dlv_msg.mode;
  assign dlv_level     = dlv_msg.level;

endmodule

// File: rtl/irq_route_engine_chk.sv
module irq_route_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       dlv_valid,
  input logic       dlv_ready,
  input logic [7:0] dlv_vector,
  input logic [7:0] dlv_dest,
  input logic       dlv_dest_mode,
  input logic [2:0] dlv_mode,
  input logic       dlv_level,
  input logic       ext_req,
  input logic       ext_ack
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!dlv_valid && !ext_req));

  p_hold_valid_r12: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !dlv_ready) |=> dlv_valid);

  p_hold_payload_r12: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !dlv_ready) |=>
      $stable({dlv_vector, dlv_dest, dlv_dest_mode, dlv_mode, dlv_level}));

  p_single_outstanding_r12: assert property (@(posedge clk) disable iff (rst)
    !(dlv_valid && ext_req));

  p_fetch_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (ext_req && !ext_ack) |=> ext_req);

  p_fetch_path_r11: assert property (@(posedge clk) disable iff (rst)
    ($rose(dlv_valid) && !$past(ext_req && ext_ack)) |-> (dlv_mode != 3'b111));

endmodule

bind irq_route_engine irq_route_engine_chk u_chk (.*);

// File: tb/irq_route_engine_tb.sv
module irq_route_engine_tb;

  localparam int NP = 8;
  localparam int SW = 4;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          src_valid = 1'b0;
  logic [SW-1:0] src_idx = '0;
  logic          src_level = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [PW-1:0] cfg_wr_pin = '0;
  logic [63:0]   cfg_wr_data = '0;
  logic [PW-1:0] cfg_rd_pin = '0;
  logic [63:0]   cfg_rd_data;
  logic          eoi_valid = 1'b0;
  logic [7:0]    eoi_vector = '0;
  logic          dlv_valid;
  logic          dlv_ready = 1'b0;
  logic [7:0]    dlv_vector, dlv_dest;
  logic          dlv_dest_mode, dlv_level;
  logic [2:0]    dlv_mode;
  logic          ext_req;
  logic          ext_ack = 1'b0;
  logic [7:0]    ext_vector = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_route_engine #(.NUM_PINS(NP), .SRC_W(SW)) u_dut (.*);

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] mode,
                                     input logic dm, input logic pol, input logic trig,
                                     input logic msk, input logic [7:0] dest);
    return {dest, 39'b0, msk, trig, 1'b0, pol, 1'b0, dm, mode, vec};
  endfunction

  function automatic logic [7:0] vec_of(input int p);  return 8'(32'h20 + p); endfunction
  function automatic logic [7:0] dest_of(input int p); return 8'(p * 3 + 1); endfunction
  function automatic logic [2:0] mode_of(input int p); return 3'((p * 5) % 7); endfunction

  function automatic logic [63:0] std_entry(input int p, input logic msk);
    return mk(vec_of(p), mode_of(p), 1'(p & 1), 1'b0, 1'b0, msk, dest_of(p));
  endfunction

  function automatic logic [20:0] exp_msg(input int p, input logic lvl);
    return {vec_of(p), dest_of(p), 1'(p & 1), mode_of(p), lvl};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int p, input logic [63:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_pin = PW'(p); cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic send(input int idx, input logic lvl);
    @(negedge clk);
    src_valid = 1'b1; src_idx = SW'(idx); src_level = lvl;
    @(negedge clk);
    src_valid = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic rd(input int p, output logic [63:0] d);
    @(negedge clk);
    cfg_rd_pin = PW'(p);
    #1 d = cfg_rd_data;
  endtask

  task automatic take(input string tag, input logic [20:0] exp);
    bit seen = 0;
    for (int k = 0; k < 50 && !seen; k++) begin
      @(negedge clk);
      if (dlv_valid) seen = 1;
    end
    check(tag, "delivery seen", 64'(seen), 64'd1);
    if (seen) begin
      check(tag, "delivery payload",
            64'({dlv_vector, dlv_dest, dlv_dest_mode, dlv_mode, dlv_level}), 64'(exp));
      dlv_ready = 1'b1;
      @(negedge clk);
      dlv_ready = 1'b0;
    end
  endtask

  task automatic none(input int n, input string tag);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (dlv_valid || ext_req) seen = 1;
    end
    check(tag, "no delivery", 64'(seen), 64'd0);
  endtask

  task automatic mask_all();
    for (int p = 0; p < NP; p++) wr(p, std_entry(p, 1'b1));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] d;
    logic [63:0] pat;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1", "dlv_valid after reset", 64'(dlv_valid), 64'd0);
    check("R1", "ext_req after reset", 64'(ext_req), 64'd0);
    for (int p = 0; p < NP; p++) begin
      rd(p, d);
      check("R1", "entry after reset", d, 64'h0000_0000_0001_0000);
    end

    // R2: writable fields, remote and reserved bits read zero
    for (int p = 0; p < NP; p++) begin
      pat = 64'hFFFF_FFFF_FFFF_FFFF ^ (64'(p) << 56) ^ (64'(p) * 64'h111);
      wr(p, pat);
      rd(p, d);
      check("R2", "entry readback", d, pat & 64'hFF00_0000_0001_AFFF);
    end
    mask_all();

    // R6, R8, R5, R9: sweep every source number over edge-mode pins
    for (int p = 0; p < NP; p++) wr(p, std_entry(p, 1'b0));
    for (int s = 0; s < (1 << SW); s++) begin
      int pin;
      pin = (s == 0) ? 2 : s;
      send(s, 1'b1);
      if (pin < NP) take("R6_R8", exp_msg(pin, 1'b0));
      else          none(8, "R6 out-of-range source");
      send(s, 1'b0);
      none(6, "R5_R9 single edge delivery");
    end

    // R7, R12: stall top pin, queue lower pins, expect ascending order
    send(7, 1'b1);
    for (int k = 0; k < 30 && !dlv_valid; k++) @(negedge clk);
    send(6, 1'b1);
    send(1, 1'b1);
    send(3, 1'b1);
    check("R12", "held valid during stall", 64'(dlv_valid), 64'd1);
    check("R12", "held vector during stall", 64'(dlv_vector), 64'(vec_of(7)));
    check("R12", "no fetch during stall", 64'(ext_req), 64'd0);
    take("R12", exp_msg(7, 1'b0));
    take("R7 first", exp_msg(1, 1'b0));
    take("R7 second", exp_msg(3, 1'b0));
    take("R7 third", exp_msg(6, 1'b0));
    none(8, "R7 drained");
    mask_all();

    // R3: polarity inversion on an edge pin
    wr(4, mk(vec_of(4), mode_of(4), 1'b0, 1'b1, 1'b0, 1'b0, dest_of(4)));
    send(4, 1'b1);
    none(8, "R3 high level inactive");
    send(4, 1'b0);
    take("R3", {vec_of(4), dest_of(4), 1'b0, mode_of(4), 1'b0});
    mask_all();

    // R5: masked edge is discarded
    send(3, 1'b1);
    send(3, 1'b0);
    wr(3, std_entry(3, 1'b0));
    none(10, "R5 masked edge dropped");
    mask_all();

    // R4: level mode, masked pending then withdrawn
    wr(5, mk(8'h45, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h5A));
    send(5, 1'b1);
    none(8, "R4 masked level held");
    send(5, 1'b0);
    wr(5, mk(8'h45, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h5A));
    none(10, "R4 withdrawn request");
    wr(5, mk(8'h45, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h5A));
    send(5, 1'b1);
    wr(5, mk(8'h45, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h5A));
    take("R4", {8'h45, 8'h5A, 1'b1, 3'd1, 1'b1});
    rd(5, d);
    check("R9", "remote-pending set", 64'(d[14]), 64'd1);
    send(5, 1'b1);
    none(10, "R9 blocked while remote-pending");
    eoi(8'h46);
    none(8, "R10 non-matching eoi");
    rd(5, d);
    check("R10", "remote kept on mismatch", 64'(d[14]), 64'd1);
    eoi(8'h45);
    take("R10 redelivery", {8'h45, 8'h5A, 1'b1, 3'd1, 1'b1});
    send(5, 1'b0);
    eoi(8'h45);
    none(10, "R10 no redelivery when idle");
    rd(5, d);
    check("R10", "remote cleared", 64'(d[14]), 64'd0);
    mask_all();

    // R11: external vector fetch
    wr(6, mk(8'h66, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 8'h12));
    send(6, 1'b1);
    for (int k = 0; k < 30 && !ext_req; k++) @(negedge clk);
    check("R11", "fetch requested", 64'(ext_req), 64'd1);
    repeat (3) @(negedge clk);
    check("R11", "fetch held", 64'(ext_req), 64'd1);
    check("R11", "no message before ack", 64'(dlv_valid), 64'd0);
    ext_vector = 8'h9A;
    ext_ack = 1'b1;
    @(negedge clk);
    ext_ack = 1'b0;
    check("R11", "fetch closed", 64'(ext_req), 64'd0);
    take("R11", {8'h9A, 8'h12, 1'b0, 3'b111, 1'b0});
    none(8, "R11 single message");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule